// File: doc/BRIEF.md
# L1 Access Latency Pipeline Queue

This block puts a fixed access latency in front of a level-1 data cache. A load/store unit hands it one memory request at a time. Each request enters the last slot of a short shift pipeline whose depth is the configured latency. It then walks one slot per cycle toward slot 0, the head. The head entry is offered to the cache every cycle. The cache answers in the same cycle with exactly one of hit, miss, hit-reserved or reservation-fail. The first three retire the entry. A reservation failure keeps it at the head so it can try again.

Any empty slot pulls in the entry behind it, so gaps in the pipeline close up. The block also keeps two sets of counters. The first holds the store acknowledgements each warp is still owed. The second holds how many loads in flight still target each destination register of each warp. When a load hits and the count for one of its registers reaches zero, the block pulses a release for that register. With a latency of zero the pipeline is left out and each request goes straight to the cache port.

The request side is a valid/ready stream. `req_ready` depends only on whether the last slot was empty at the start of the cycle. A request offered while `req_ready` is low stays with the requester and is reported as a bank-conflict stall. The requester must hold it until a later cycle. The cache side has no back-pressure of its own. A reservation failure is the cache's way of refusing.

Top module: `l1_lat_queue`

## Requirements
- R1: After reset every slot is empty, `cache_valid` is 0, `req_ready` is 1, and every outstanding-store count reads 0.
- R2: `req_ready` equals "last slot empty at the start of the cycle". A slot that is freed by movement in a cycle accepts a new request only in the next cycle. A request offered while `req_ready` is 0 is not taken, and `req_stall` reads 1 (bank conflict).
- R3: When a request is taken, `req_stall` reads 2 (coalescing) if `req_more` is 1, and 0 otherwise. With no request offered it reads 0.
- R4: Taking a store adds to its warp's outstanding-store count. The amount is `req_bytes / SECTOR_BYTES` when SECTORED is 1, and 1 when SECTORED is 0.
- R5: While the head is valid, `cache_valid` is 1 and the head fields are shown on the `cache_*` pins. A hit, miss or hit-reserved response retires the head. A reservation-fail response keeps the same entry at the head for the next cycle.
- R6: After the head is handled, slots are swept from 0 upward. Each empty slot takes the entry of the slot behind it, so an entry advances at most one slot per cycle. With no blocking, a request taken at clock edge N reaches the head after edge N+LATENCY-1. Requests reach the head in the order they were taken.
- R7: A load that hits decrements the pending count of each nonzero destination field. Register index 0 means "no register". The four fields of one load name distinct registers. A `pend_inc_valid` pulse adds 1 to the named counter in the same cycle. Bit k of `rel_mask` (field k is `cache_dst[k*REG_W +: REG_W]`) pulses in the hit cycle when the updated count for field k's register is zero. `inst_done` pulses whenever any bit of `rel_mask` is set.
- R8: A store that hits with `rsp_write_sent` low pulses `ack_valid`, with `ack_count` equal to the R4 amount, and that warp's outstanding count drops by the same amount. A store that hits with `rsp_write_sent` high, or that gets any other response, produces no acknowledgement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Last slot free; request taken when valid and ready |
| req_warp | input | WARP_W | Warp of the request |
| req_store | input | 1 | 1 for store, 0 for load |
| req_bytes | input | BYTE_W | Access size in bytes |
| req_dst | input | NDST*REG_W | Load destination registers, 0 = unused |
| req_more | input | 1 | Same instruction has further requests to issue |
| req_stall | output | 2 | 0 none, 1 bank conflict, 2 coalescing |
| pend_inc_valid | input | 1 | Add one pending load write |
| pend_inc_warp | input | WARP_W | Warp of that pending write |
| pend_inc_reg | input | REG_W | Register of that pending write |
| cache_valid | output | 1 | Head entry offered to the cache |
| cache_warp | output | WARP_W | Head warp |
| cache_store | output | 1 | Head is a store |
| cache_bytes | output | BYTE_W | Head access size |
| cache_dst | output | NDST*REG_W | Head destination registers |
| rsp_hit | input | 1 | Cache hit |
| rsp_miss | input | 1 | Cache miss |
| rsp_hit_rsv | input | 1 | Hit on a reserved line |
| rsp_rsv_fail | input | 1 | Reservation failure, retry |
| rsp_write_sent | input | 1 | Cache forwarded a write downstream |
| rsp_read_sent | input | 1 | Cache forwarded a read downstream |
| ack_valid | output | 1 | Store acknowledgement pulse |
| ack_count | output | BYTE_W | Number of acknowledgements in the pulse |
| rel_mask | output | NDST | Scoreboard release, one bit per destination field |
| inst_done | output | 1 | Instruction-complete pulse |
| store_outstanding | output | NUM_WARPS*CNT_W | Outstanding-store count per warp, warp w at bits w*CNT_W |

## Verification
The bench builds two copies with a latency of 3, two warps and eight registers. One copy uses SECTORED=1 with 32-byte sectors, and the other uses SECTORED=0. Both copies are fed the same stimulus, so one run checks both the sector-based amount and the fixed amount of one. A latency of 3 is deep enough to show a held head, a gap closing behind it, a full pipeline refusing a request, and the one-cycle delay before a freed tail can be reused. Long pseudo-random phases are run in turn, some heavy with reservation failures and some heavy with hits. Together they reach every response type with loads and stores at the head, acknowledgements with and without a forwarded write, and register counts that fall to zero alongside same-cycle increments.

// File: rtl/l1q_pkg.sv
package l1q_pkg;
  typedef enum logic [1:0] {
    STALL_NONE = 2'd0,
    STALL_BANK = 2'd1,
    STALL_COAL = 2'd2
  } stall_e;
endpackage

// File: rtl/l1q_slot_pipe.sv
module l1q_slot_pipe #(
  parameter int LATENCY = 3,
  parameter int ENT_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [ENT_W-1:0] in_data,
  output logic             in_ready,
  output logic             head_valid,
  output logic [ENT_W-1:0] head_data,
  input  logic             head_retire
);
  generate
    if (LATENCY == 0) begin : g_bypass
      assign head_valid = in_valid;
      assign head_data  = in_data;
      assign in_ready   = head_retire;
    end else begin : g_pipe
      logic [LATENCY-1:0] vld_q, vld_n;
      logic [ENT_W-1:0]   dat_q [LATENCY];
      logic [ENT_W-1:0]   dat_n [LATENCY];

      assign in_ready   = !vld_q[LATENCY-1];
      assign head_valid = vld_q[0];
      assign head_data  = dat_q[0];

      always_comb begin
        vld_n = vld_q;
        for (int s = 0; s < LATENCY; s++) dat_n[s] = dat_q[s];
        if (vld_n[0] && head_retire) vld_n[0] = 1'b0;
        for (int s = 0; s < LATENCY - 1; s++) begin
          if (!vld_n[s]) begin
            vld_n[s]   = vld_n[s+1];
            dat_n[s]   = dat_n[s+1];
            vld_n[s+1] = 1'b0;
          end
        end
        if (in_valid && in_ready) begin
          vld_n[LATENCY-1] = 1'b1;
          dat_n[LATENCY-1] = in_data;
        end
      end

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          vld_q <= '0;
          for (int s = 0; s < LATENCY; s++) dat_q[s] <= '0;
        end else begin
          vld_q <= vld_n;
          for (int s = 0; s < LATENCY; s++) dat_q[s] <= dat_n[s];
        end
      end

      // R5: a refused head stays put with unchanged contents
      p_hold_head_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (head_valid && !head_retire) |=> (head_valid && head_data == $past(head_data)));

      // R6: occupancy changes only by one retire and one accept per cycle
      p_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ($countones(vld_q) == $past($countones(vld_q))
                   - $past(int'(head_valid && head_retire))
                   + $past(int'(in_valid && in_ready))));

      if (LATENCY > 1) begin : g_adv
        // R6: an entry behind an empty head moves exactly one slot
        p_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
          (!vld_q[0] && vld_q[1]) |=> (vld_q[0] && dat_q[0] == $past(dat_q[1])));
      end
    end
  endgenerate
endmodule

// File: rtl/l1q_store_track.sv
module l1q_store_track #(
  parameter int NUM_WARPS = 4,
  parameter int WARP_W    = 2,
  parameter int AMT_W     = 8,
  parameter int CNT_W     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       inc_valid,
  input  logic [WARP_W-1:0]          inc_warp,
  input  logic [AMT_W-1:0]           inc_amt,
  input  logic                       dec_valid,
  input  logic [WARP_W-1:0]          dec_warp,
  input  logic [AMT_W-1:0]           dec_amt,
  output logic [NUM_WARPS*CNT_W-1:0] counts
);
  logic [CNT_W-1:0] cnt_q [NUM_WARPS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < NUM_WARPS; w++) cnt_q[w] <= '0;
    end else begin
      for (int w = 0; w < NUM_WARPS; w++) begin
        cnt_q[w] <= cnt_q[w]
          + ((inc_valid && inc_warp == WARP_W'(w)) ? CNT_W'(inc_amt) : '0)
          - ((dec_valid && dec_warp == WARP_W'(w)) ? CNT_W'(dec_amt) : '0);
      end
    end
  end

  generate
    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_out
      assign counts[w*CNT_W +: CNT_W] = cnt_q[w];
    end
  endgenerate

  // R8: an acknowledgement never exceeds what the warp is owed
  p_ack_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> (cnt_q[dec_warp] >= CNT_W'(dec_amt)));
endmodule

// File: rtl/l1q_pend_track.sv
module l1q_pend_track #(
  parameter int NUM_WARPS = 4,
  parameter int WARP_W    = 2,
  parameter int NUM_REGS  = 16,
  parameter int REG_W     = 4,
  parameter int NDST      = 4,
  parameter int PEND_W    = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  inc_valid,
  input  logic [WARP_W-1:0]     inc_warp,
  input  logic [REG_W-1:0]      inc_reg,
  input  logic                  dec_valid,
  input  logic [WARP_W-1:0]     dec_warp,
  input  logic [NDST*REG_W-1:0] dec_regs,
  output logic [NDST-1:0]       rel_mask
);
  logic [PEND_W-1:0] cnt_q [NUM_WARPS][NUM_REGS];
  logic [PEND_W-1:0] nxt   [NUM_WARPS][NUM_REGS];
  logic [REG_W-1:0]  dst_r [NDST];

  generate
    for (genvar k = 0; k < NDST; k++) begin : g_dst
      assign dst_r[k] = dec_regs[k*REG_W +: REG_W];
      // R7: a register is never released below zero
      p_pend_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dst_r[k] != '0) |-> (cnt_q[dec_warp][dst_r[k]] != '0));
    end
  endgenerate

  always_comb begin
    logic [PEND_W-1:0] dcnt;
    for (int w = 0; w < NUM_WARPS; w++) begin
      for (int r = 0; r < NUM_REGS; r++) begin
        dcnt = '0;
        for (int k = 0; k < NDST; k++) begin
          if (dec_valid && r != 0 && dec_warp == WARP_W'(w) && dst_r[k] == REG_W'(r))
            dcnt = dcnt + PEND_W'(1);
        end
        nxt[w][r] = cnt_q[w][r]
          + PEND_W'(inc_valid && inc_warp == WARP_W'(w) && inc_reg == REG_W'(r))
          - dcnt;
      end
    end
    for (int k = 0; k < NDST; k++)
      rel_mask[k] = dec_valid && dst_r[k] != '0 && nxt[dec_warp][dst_r[k]] == '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < NUM_WARPS; w++)
        for (int r = 0; r < NUM_REGS; r++) cnt_q[w][r] <= '0;
    end else begin
      for (int w = 0; w < NUM_WARPS; w++)
        for (int r = 0; r < NUM_REGS; r++) cnt_q[w][r] <= nxt[w][r];
    end
  end
endmodule

// File: rtl/l1_lat_queue.sv
module l1_lat_queue #(
  parameter int LATENCY      = 3,
  parameter int NUM_WARPS    = 4,
  parameter int NUM_REGS     = 16,
  parameter int NDST         = 4,
  parameter int BYTE_W       = 8,
  parameter int SECTOR_BYTES = 32,
  parameter bit SECTORED     = 1'b1,
  parameter int CNT_W        = 8,
  parameter int PEND_W       = 4,
  localparam int WARP_W      = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
  localparam int REG_W       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [WARP_W-1:0]          req_warp,
  input  logic                       req_store,
  input  logic [BYTE_W-1:0]          req_bytes,
  input  logic [NDST*REG_W-1:0]      req_dst,
  input  logic                       req_more,
  output logic [1:0]                 req_stall,
  input  logic                       pend_inc_valid,
  input  logic [WARP_W-1:0]          pend_inc_warp,
  input  logic [REG_W-1:0]           pend_inc_reg,
  output logic                       cache_valid,
  output logic [WARP_W-1:0]          cache_warp,
  output logic                       cache_store,
  output logic [BYTE_W-1:0]          cache_bytes,
  output logic [NDST*REG_W-1:0]      cache_dst,
  input  logic                       rsp_hit,
  input  logic                       rsp_miss,
  input  logic                       rsp_hit_rsv,
  input  logic                       rsp_rsv_fail,
  input  logic                       rsp_write_sent,
  input  logic                       rsp_read_sent,
  output logic                       ack_valid,
  output logic [BYTE_W-1:0]          ack_count,
  output logic [NDST-1:0]            rel_mask,
  output logic                       inst_done,
  output logic [NUM_WARPS*CNT_W-1:0] store_outstanding
);
  import l1q_pkg::*;

  localparam int DST_W  = NDST * REG_W;
  localparam int ENT_W  = WARP_W + 1 + BYTE_W + DST_W;
  localparam int SEC_SH = (SECTOR_BYTES > 1) ? $clog2(SECTOR_BYTES) : 0;

  logic [ENT_W-1:0]  in_ent, head_ent;
  logic              head_retire, accept, load_hit;
  logic [BYTE_W-1:0] enq_amt;
  stall_e            stall;

  function automatic logic [BYTE_W-1:0] sectors(input logic [BYTE_W-1:0] nbytes);
    if (SECTORED) return nbytes >> SEC_SH;
    else          return BYTE_W'(1);
  endfunction

  assign in_ent      = {req_warp, req_store, req_bytes, req_dst};
  assign head_retire = rsp_hit || rsp_miss || rsp_hit_rsv;
  assign accept      = req_valid && req_ready;

  l1q_slot_pipe #(.LATENCY(LATENCY), .ENT_W(ENT_W)) u_pipe (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (req_valid),
    .in_data     (in_ent),
    .in_ready    (req_ready),
    .head_valid  (cache_valid),
    .head_data   (head_ent),
    .head_retire (head_retire)
  );

  assign cache_dst   = head_ent[DST_W-1:0];
  assign cache_bytes = head_ent[DST_W +: BYTE_W];
  assign cache_store = head_ent[DST_W + BYTE_W];
  assign cache_warp  = head_ent[DST_W + BYTE_W + 1 +: WARP_W];

  always_comb begin
    stall = STALL_NONE;
    if (req_valid) begin
      if (!req_ready)    stall = STALL_BANK;
      else if (req_more) stall = STALL_COAL;
    end
  end
  assign req_stall = stall;

  assign enq_amt   = sectors(req_bytes);
  assign ack_valid = cache_valid && rsp_hit && cache_store && !rsp_write_sent;
  assign ack_count = ack_valid ? sectors(cache_bytes) : '0;
  assign load_hit  = cache_valid && rsp_hit && !cache_store;
  assign inst_done = |rel_mask;

  l1q_store_track #(
    .NUM_WARPS(NUM_WARPS), .WARP_W(WARP_W), .AMT_W(BYTE_W), .CNT_W(CNT_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .inc_valid (accept && req_store),
    .inc_warp  (req_warp),
    .inc_amt   (enq_amt),
    .dec_valid (ack_valid),
    .dec_warp  (cache_warp),
    .dec_amt   (ack_count),
    .counts    (store_outstanding)
  );

  l1q_pend_track #(
    .NUM_WARPS(NUM_WARPS), .WARP_W(WARP_W), .NUM_REGS(NUM_REGS),
    .REG_W(REG_W), .NDST(NDST), .PEND_W(PEND_W)
  ) u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .inc_valid (pend_inc_valid),
    .inc_warp  (pend_inc_warp),
    .inc_reg   (pend_inc_reg),
    .dec_valid (load_hit),
    .dec_warp  (cache_warp),
    .dec_regs  (cache_dst),
    .rel_mask  (rel_mask)
  );

  // R5: the cache answers an offered head with exactly one response
  p_rsp_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cache_valid |-> ($countones({rsp_hit, rsp_miss, rsp_hit_rsv, rsp_rsv_fail}) == 1));

  // R5: a hit must not claim that a read went downstream
  p_hit_no_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cache_valid && rsp_hit) |-> !rsp_read_sent);

  // R5: a refused access forwards nothing
  p_fail_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cache_valid && rsp_rsv_fail) |-> (!rsp_read_sent && !rsp_write_sent));
endmodule

// File: tb/l1_lat_queue_test.sv
module l1_lat_queue_test;
  localparam int LAT = 3;
  localparam int NW  = 2;
  localparam int NR  = 8;
  localparam int ND  = 4;
  localparam int RW  = 3;
  localparam int CW  = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n;
  logic req_valid, req_store, req_more, req_warp;
  logic [7:0] req_bytes;
  logic [ND*RW-1:0] req_dst;
  logic pend_inc_valid, pend_inc_warp;
  logic [RW-1:0] pend_inc_reg;
  logic rsp_hit, rsp_miss, rsp_hit_rsv, rsp_rsv_fail, rsp_write_sent, rsp_read_sent;

  logic req_ready, cache_valid, cache_store, ack_valid, inst_done, cache_warp;
  logic [1:0] req_stall;
  logic [7:0] cache_bytes, ack_count;
  logic [ND*RW-1:0] cache_dst;
  logic [ND-1:0] rel_mask;
  logic [NW*CW-1:0] store_outstanding;

  logic f_ready, f_cvalid, f_cstore, f_ack, f_done, f_cwarp;
  logic [1:0] f_stall;
  logic [7:0] f_cbytes, f_ackc;
  logic [ND*RW-1:0] f_cdst;
  logic [ND-1:0] f_rel;
  logic [NW*CW-1:0] f_out;

  l1_lat_queue #(.LATENCY(LAT), .NUM_WARPS(NW), .NUM_REGS(NR), .NDST(ND),
    .BYTE_W(8), .SECTOR_BYTES(32), .SECTORED(1'b1), .CNT_W(CW), .PEND_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_warp(req_warp), .req_store(req_store), .req_bytes(req_bytes),
    .req_dst(req_dst), .req_more(req_more), .req_stall(req_stall),
    .pend_inc_valid(pend_inc_valid), .pend_inc_warp(pend_inc_warp), .pend_inc_reg(pend_inc_reg),
    .cache_valid(cache_valid), .cache_warp(cache_warp), .cache_store(cache_store),
    .cache_bytes(cache_bytes), .cache_dst(cache_dst),
    .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_hit_rsv(rsp_hit_rsv),
    .rsp_rsv_fail(rsp_rsv_fail), .rsp_write_sent(rsp_write_sent), .rsp_read_sent(rsp_read_sent),
    .ack_valid(ack_valid), .ack_count(ack_count), .rel_mask(rel_mask),
    .inst_done(inst_done), .store_outstanding(store_outstanding));

  l1_lat_queue #(.LATENCY(LAT), .NUM_WARPS(NW), .NUM_REGS(NR), .NDST(ND),
    .BYTE_W(8), .SECTOR_BYTES(32), .SECTORED(1'b0), .CNT_W(CW), .PEND_W(4)) uut_flat (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(f_ready),
    .req_warp(req_warp), .req_store(req_store), .req_bytes(req_bytes),
    .req_dst(req_dst), .req_more(req_more), .req_stall(f_stall),
    .pend_inc_valid(pend_inc_valid), .pend_inc_warp(pend_inc_warp), .pend_inc_reg(pend_inc_reg),
    .cache_valid(f_cvalid), .cache_warp(f_cwarp), .cache_store(f_cstore),
    .cache_bytes(f_cbytes), .cache_dst(f_cdst),
    .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_hit_rsv(rsp_hit_rsv),
    .rsp_rsv_fail(rsp_rsv_fail), .rsp_write_sent(rsp_write_sent), .rsp_read_sent(rsp_read_sent),
    .ack_valid(f_ack), .ack_count(f_ackc), .rel_mask(f_rel),
    .inst_done(f_done), .store_outstanding(f_out));

  int nchk = 0;
  int nfail = 0;
  bit finished = 1'b0;
  logic [31:0] seed = 32'h1234_5679;

  // bench model of the requirements
  bit        mv [LAT];
  bit        mw [LAT];
  bit        ms [LAT];
  int        mb [LAT];
  bit [3:0]  mm [LAT];
  int        pend [NW][NR];
  int        outs [NW];
  int        outf [NW];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  initial begin
    #(200000 * 20);
    if (!finished) begin
      nfail++;
      nchk++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 0; req_store = 0; req_more = 0; req_warp = 0; req_bytes = 0; req_dst = 0;
    pend_inc_valid = 0; pend_inc_warp = 0; pend_inc_reg = 0;
    rsp_hit = 0; rsp_miss = 0; rsp_hit_rsv = 0; rsp_rsv_fail = 0;
    rsp_write_sent = 0; rsp_read_sent = 0;
    for (int s = 0; s < LAT; s++) begin mv[s] = 0; mw[s] = 0; ms[s] = 0; mb[s] = 0; mm[s] = 0; end
    for (int w = 0; w < NW; w++) begin
      outs[w] = 0; outf[w] = 0;
      for (int r = 0; r < NR; r++) pend[w][r] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
    chk(cache_valid == 1'b0, "R1 cache_valid", cache_valid, 0);
    chk(store_outstanding == '0, "R1 outstanding", store_outstanding, 0);
    chk(f_out == '0, "R1 outstanding flat", f_out, 0);
    @(negedge clk);

    for (int cyc = 0; cyc < 2000; cyc++) begin
      int phase;
      int pick;
      bit hit_ok;
      bit exp_ack;
      bit [3:0] exp_rel;
      bit acc;
      bit [3:0] m;
      phase = (cyc / 250) % 4;

      // R4/R8: outstanding counts registered from the previous cycle
      for (int w = 0; w < NW; w++) begin
        chk(store_outstanding[w*CW +: CW] == outs[w][7:0], "R4 R8 outstanding sectored",
            store_outstanding[w*CW +: CW], outs[w]);
        chk(f_out[w*CW +: CW] == outf[w][7:0], "R4 R8 outstanding flat",
            f_out[w*CW +: CW], outf[w]);
      end

      // drive request
      req_valid = (phase == 2) ? (rnd() % 8 != 0) : (rnd() % 3 != 0);
      req_warp  = rnd() % 2;
      req_store = rnd() % 2;
      req_more  = rnd() % 2;
      req_bytes = 8'(32 * (1 + rnd() % 4));
      m = rnd() % 16;
      if (req_store) m = 4'd0;
      for (int k = 0; k < ND; k++) req_dst[k*RW +: RW] = m[k] ? RW'(k + 1) : RW'(0);

      pend_inc_valid = (rnd() % 2 == 0);
      pend_inc_warp  = rnd() % 2;
      pend_inc_reg   = RW'(1 + rnd() % 4);
      if (pend[pend_inc_warp][pend_inc_reg] >= 12) pend_inc_valid = 1'b0;

      // drive response
      rsp_hit = 0; rsp_miss = 0; rsp_hit_rsv = 0; rsp_rsv_fail = 0; rsp_write_sent = 0;
      if (mv[0]) begin
        pick = rnd() % 8;
        if ((phase == 0 || phase == 2) && pick < 5) rsp_rsv_fail = 1;
        else if (pick == 0) rsp_rsv_fail = 1;
        else if (pick == 1) rsp_miss = 1;
        else if (pick == 2) rsp_hit_rsv = 1;
        else begin
          hit_ok = 1;
          for (int k = 0; k < ND; k++)
            if (!ms[0] && mm[0][k] && pend[mw[0]][k+1] < 1) hit_ok = 0;
          if (hit_ok) rsp_hit = 1; else rsp_miss = 1;
        end
        if (!rsp_rsv_fail) rsp_write_sent = (rnd() % 3 == 0);
      end

      #1;
      // R2 / R3 handshake and stall code
      chk(req_ready == !mv[LAT-1], "R2 ready", req_ready, !mv[LAT-1]);
      chk(f_ready == !mv[LAT-1], "R2 ready flat", f_ready, !mv[LAT-1]);
      acc = req_valid && !mv[LAT-1];
      if (req_valid && mv[LAT-1])
        chk(req_stall == 2'd1, "R2 bank stall", req_stall, 1);
      else if (acc && req_more)
        chk(req_stall == 2'd2, "R3 coalesce stall", req_stall, 2);
      else
        chk(req_stall == 2'd0, "R3 no stall", req_stall, 0);

      // R5 / R6 head contents and order
      chk(cache_valid == mv[0], "R5 cache_valid", cache_valid, mv[0]);
      if (mv[0]) begin
        chk(cache_warp == mw[0] && cache_store == ms[0] && cache_bytes == 8'(mb[0]),
            "R6 head entry", {cache_warp, cache_store, cache_bytes}, {mw[0], ms[0], 8'(mb[0])});
        for (int k = 0; k < ND; k++)
          chk(cache_dst[k*RW +: RW] == (mm[0][k] ? RW'(k + 1) : RW'(0)), "R6 head dst",
              cache_dst[k*RW +: RW], mm[0][k] ? k + 1 : 0);
      end

      // R8 acknowledgements
      exp_ack = mv[0] && rsp_hit && ms[0] && !rsp_write_sent;
      chk(ack_valid == exp_ack, "R8 ack_valid", ack_valid, exp_ack);
      chk(f_ack == exp_ack, "R8 ack_valid flat", f_ack, exp_ack);
      if (exp_ack) begin
        chk(ack_count == 8'(mb[0] / 32), "R8 ack_count", ack_count, mb[0] / 32);
        chk(f_ackc == 8'd1, "R8 ack_count flat", f_ackc, 1);
      end

      // R7 register release
      exp_rel = '0;
      for (int w = 0; w < NW; w++)
        for (int r = 0; r < NR; r++)
          if (pend_inc_valid && pend_inc_warp == w[0] && pend_inc_reg == RW'(r)) pend[w][r]++;
      if (mv[0] && rsp_hit && !ms[0]) begin
        for (int k = 0; k < ND; k++)
          if (mm[0][k]) begin
            pend[mw[0]][k+1]--;
            exp_rel[k] = (pend[mw[0]][k+1] == 0);
          end
      end
      chk(rel_mask == exp_rel, "R7 rel_mask", rel_mask, exp_rel);
      chk(inst_done == (exp_rel != 0), "R7 inst_done", inst_done, exp_rel != 0);

      // model update: retire, sweep, tail accept
      if (exp_ack) begin
        outs[mw[0]] -= mb[0] / 32;
        outf[mw[0]] -= 1;
      end
      if (acc && req_store) begin
        outs[req_warp] += req_bytes / 32;
        outf[req_warp] += 1;
      end
      if (mv[0] && (rsp_hit || rsp_miss || rsp_hit_rsv)) mv[0] = 0;
      for (int s = 0; s < LAT - 1; s++)
        if (!mv[s]) begin
          mv[s] = mv[s+1]; mw[s] = mw[s+1]; ms[s] = ms[s+1]; mb[s] = mb[s+1]; mm[s] = mm[s+1];
          mv[s+1] = 0;
        end
      if (acc) begin
        mv[LAT-1] = 1; mw[LAT-1] = req_warp; ms[LAT-1] = req_store;
        mb[LAT-1] = req_bytes; mm[LAT-1] = m;
      end
      @(negedge clk);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule